// File: doc/BRIEF.md
# Reservation Station Wakeup-Select Pool

This block is the scheduling window of an out-of-order core. It holds a small pool of waiting operations. Each slot stores an opcode, the reorder-buffer index the operation will write, and two source operands. Every source has a producer tag, a ready flag and a value. The producer tag is the reorder-buffer index of the instruction that computes that operand. Rename logic writes an operation into a free slot and passes in any operand that is already known. Writeback then broadcasts a tag and result pair. Every waiting source compares its tag against the broadcast and captures the value when the two match.

A slot whose two sources are both ready requests issue. A fixed-priority picker grants one slot per cycle to the single execution port, and the granted slot is released on the next clock. Occupancy is tracked in a free map, so slots can be released in any order. On a mispredict, a flush empties the whole pool. As an alternative, the free map can be saved at a speculation point and restored later. A restore releases every slot that was taken after the save.

Top module: `rs_pool`

## Requirements
- R1: After reset no slot is occupied, `alloc_ready` is 1 and `issue_valid` is 0.
- R2: A cycle with `alloc_valid`=1 and `alloc_ready`=1, and with neither `flush` nor `ckpt_restore`, writes the operation into the lowest-index free slot at the clock edge. A source given with its ready flag set keeps the value supplied. A source given with its ready flag clear waits for its tag.
- R3: A broadcast with `bc_valid`=1 sets every stored source whose ready flag is clear and whose tag equals `bc_tag`: that source becomes ready and takes `bc_val` at the clock edge. Sources that are already ready and sources with other tags are left unchanged.
- R4: If a broadcast arrives in the same cycle as an allocation whose source is not ready and has a matching tag, the source is stored as ready with the broadcast value.
- R5: A slot requests issue when it is occupied and both its sources are ready. In the same cycle, `issue_valid` is 1 and `issue_idx`, `issue_op`, `issue_dst`, `issue_s1_val` and `issue_s2_val` show the lowest-index requesting slot. At most one slot is granted per cycle.
- R6: A granted slot is free from the next cycle and can be allocated again. The release does not depend on the state of any other slot.
- R7: `alloc_ready` is 0 exactly when every slot is occupied. A request made while it is 0 is dropped and changes no slot.
- R8: `flush`=1 frees every slot at the clock edge. Any allocation in that cycle is dropped.
- R9: `ckpt_save`=1 records the occupancy as it stands at the start of the cycle. `ckpt_restore`=1 leaves a slot occupied only if it was recorded as occupied and is still occupied and not granted. Any allocation in that cycle is dropped, and the restore uses the record held before any save in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Free all slots |
| ckpt_save | input | 1 | Record current occupancy |
| ckpt_restore | input | 1 | Return occupancy to the recorded map |
| alloc_valid | input | 1 | Allocation request |
| alloc_op | input | 4 | Opcode to store |
| alloc_dst | input | 4 | Destination reorder-buffer index |
| alloc_s1_tag | input | 4 | Source 1 producer tag |
| alloc_s1_rdy | input | 1 | Source 1 value already known |
| alloc_s1_val | input | 16 | Source 1 value |
| alloc_s2_tag | input | 4 | Source 2 producer tag |
| alloc_s2_rdy | input | 1 | Source 2 value already known |
| alloc_s2_val | input | 16 | Source 2 value |
| alloc_ready | output | 1 | At least one slot is free |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | 4 | Broadcast producer tag |
| bc_val | input | 16 | Broadcast result |
| issue_valid | output | 1 | A slot is granted this cycle |
| issue_idx | output | 3 | Granted slot |
| issue_op | output | 4 | Granted opcode |
| issue_dst | output | 4 | Granted destination index |
| issue_s1_val | output | 16 | Granted source 1 value |
| issue_s2_val | output | 16 | Granted source 2 value |

## Verification
The issue outputs and `alloc_ready` are combinational from registered slot state. The bench therefore checks them in the same cycle as the state they reflect. Allocation, wakeup, release, flush and restore all act at one clock edge. Their effect first appears in the issue outputs and `alloc_ready` of the following cycle. Inputs are driven on the falling edge and the outputs are compared 1 ns later against a bench model that is advanced once per rising edge. A result that is one cycle early or late therefore shows up as a mismatch in that cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int RS_TAG_W  = 4;
  parameter int RS_DATA_W = 16;
  parameter int RS_OP_W   = 4;

  typedef struct packed {
    logic [RS_TAG_W-1:0]  tag;
    logic                 rdy;
    logic [RS_DATA_W-1:0] val;
  } src_t;

  typedef struct packed {
    logic [RS_OP_W-1:0]  op;
    logic [RS_TAG_W-1:0] dst;
    src_t                s1;
    src_t                s2;
  } ent_t;

  // capture a broadcast into a waiting source
  function automatic src_t src_wake(src_t s, logic bv, logic [RS_TAG_W-1:0] bt,
                                    logic [RS_DATA_W-1:0] bd);
    src_t r = s;
    if (bv && !s.rdy && (s.tag == bt)) begin
      r.rdy = 1'b1;
      r.val = bd;
    end
    return r;
  endfunction

  function automatic ent_t ent_wake(ent_t e, logic bv, logic [RS_TAG_W-1:0] bt,
                                    logic [RS_DATA_W-1:0] bd);
    ent_t r = e;
    r.s1 = src_wake(e.s1, bv, bt, bd);
    r.s2 = src_wake(e.s2, bv, bt, bd);
    return r;
  endfunction
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [N-1:0]  oh,
  output logic [IW-1:0] idx
);
  always_comb begin
    oh  = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        oh    = '0;
        oh[i] = 1'b1;
        idx   = IW'(i);
      end
    end
    any = |vec;
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  ent_t                 wr_ent,
  input  logic                 bc_valid,
  input  logic [RS_TAG_W-1:0]  bc_tag,
  input  logic [RS_DATA_W-1:0] bc_val,
  output ent_t                 ent_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ent_q <= '0;
    else if (wr_en) ent_q <= ent_wake(wr_ent, bc_valid, bc_tag, bc_val);
    else            ent_q <= ent_wake(ent_q, bc_valid, bc_tag, bc_val);
  end
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 ckpt_save,
  input  logic                 ckpt_restore,
  input  logic                 alloc_valid,
  input  logic [RS_OP_W-1:0]   alloc_op,
  input  logic [RS_TAG_W-1:0]  alloc_dst,
  input  logic [RS_TAG_W-1:0]  alloc_s1_tag,
  input  logic                 alloc_s1_rdy,
  input  logic [RS_DATA_W-1:0] alloc_s1_val,
  input  logic [RS_TAG_W-1:0]  alloc_s2_tag,
  input  logic                 alloc_s2_rdy,
  input  logic [RS_DATA_W-1:0] alloc_s2_val,
  output logic                 alloc_ready,
  input  logic                 bc_valid,
  input  logic [RS_TAG_W-1:0]  bc_tag,
  input  logic [RS_DATA_W-1:0] bc_val,
  output logic                 issue_valid,
  output logic [IDX_W-1:0]     issue_idx,
  output logic [RS_OP_W-1:0]   issue_op,
  output logic [RS_TAG_W-1:0]  issue_dst,
  output logic [RS_DATA_W-1:0] issue_s1_val,
  output logic [RS_DATA_W-1:0] issue_s2_val
);
  logic [N_ENT-1:0] busy_q, ckpt_q, req, grant_oh, alloc_oh, free_vec;
  logic [IDX_W-1:0] alloc_idx, grant_idx;
  logic             alloc_fire, any_grant;
  ent_t             new_ent;
  ent_t             ent_arr [N_ENT];

  assign free_vec = ~busy_q;

  rs_pick #(.N(N_ENT)) u_free_pick (
    .vec(free_vec), .any(alloc_ready), .oh(alloc_oh), .idx(alloc_idx));

  rs_pick #(.N(N_ENT)) u_grant_pick (
    .vec(req), .any(any_grant), .oh(grant_oh), .idx(grant_idx));

  assign alloc_fire = alloc_valid & alloc_ready & ~flush & ~ckpt_restore;

  always_comb begin
    new_ent.op     = alloc_op;
    new_ent.dst    = alloc_dst;
    new_ent.s1.tag = alloc_s1_tag;
    new_ent.s1.rdy = alloc_s1_rdy;
    new_ent.s1.val = alloc_s1_val;
    new_ent.s2.tag = alloc_s2_tag;
    new_ent.s2.rdy = alloc_s2_rdy;
    new_ent.s2.val = alloc_s2_val;
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    rs_entry u_ent (
      .clk(clk), .rst_n(rst_n),
      .wr_en(alloc_fire & alloc_oh[g]), .wr_ent(new_ent),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .ent_q(ent_arr[g]));
    assign req[g] = busy_q[g] & ent_arr[g].s1.rdy & ent_arr[g].s2.rdy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      ckpt_q <= '0;
    end else begin
      if (flush)             busy_q <= '0;
      else if (ckpt_restore) busy_q <= busy_q & ckpt_q & ~grant_oh;
      else                   busy_q <= (busy_q & ~grant_oh) | (alloc_fire ? alloc_oh : '0);
      if (ckpt_save) ckpt_q <= busy_q;
    end
  end

  assign issue_valid  = any_grant;
  assign issue_idx    = grant_idx;
  assign issue_op     = ent_arr[grant_idx].op;
  assign issue_dst    = ent_arr[grant_idx].dst;
  assign issue_s1_val = ent_arr[grant_idx].s1.val;
  assign issue_s2_val = ent_arr[grant_idx].s2.val;
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int N_ENT = 8,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             ckpt_restore,
  input logic             alloc_fire,
  input logic             alloc_ready,
  input logic [IDX_W-1:0] alloc_idx,
  input logic [N_ENT-1:0] busy_q,
  input logic [N_ENT-1:0] ckpt_q,
  input logic [N_ENT-1:0] grant_oh,
  input logic             issue_valid,
  input logic [IDX_W-1:0] issue_idx
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh)); // R5
  AST_GRANT_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> busy_q[issue_idx]); // R5
  AST_GRANT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !busy_q[$past(issue_idx)]); // R6
  AST_ALLOC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> busy_q[$past(alloc_idx)]); // R2
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy_q) |-> !alloc_ready); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy_q == '0)); // R8
  AST_RESTORE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_restore && !flush) |=> ((busy_q & ~$past(ckpt_q)) == '0)); // R9
endmodule

bind rs_pool rs_pool_chk #(.N_ENT(N_ENT)) u_rs_pool_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .ckpt_restore(ckpt_restore),
  .alloc_fire(alloc_fire), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
  .busy_q(busy_q), .ckpt_q(ckpt_q), .grant_oh(grant_oh),
  .issue_valid(issue_valid), .issue_idx(issue_idx));

// File: tb/test_rs_pool.sv
`timescale 1ns/1ps
module test_rs_pool;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic flush, sv, rs, av, s1r, s2r, bv;
  logic [3:0] aop, adst, s1t, s2t, bt;
  logic [15:0] s1v, s2v, bd;
  logic ardy, iv;
  logic [2:0] iidx;
  logic [3:0] iop, idst;
  logic [15:0] iv1, iv2;

  rs_pool i_rs_pool (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ckpt_save(sv), .ckpt_restore(rs),
    .alloc_valid(av), .alloc_op(aop), .alloc_dst(adst),
    .alloc_s1_tag(s1t), .alloc_s1_rdy(s1r), .alloc_s1_val(s1v),
    .alloc_s2_tag(s2t), .alloc_s2_rdy(s2r), .alloc_s2_val(s2v),
    .alloc_ready(ardy), .bc_valid(bv), .bc_tag(bt), .bc_val(bd),
    .issue_valid(iv), .issue_idx(iidx), .issue_op(iop), .issue_dst(idst),
    .issue_s1_val(iv1), .issue_s2_val(iv2));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit m_busy [N], m_ck [N], m_r1 [N], m_r2 [N];
  logic [3:0] m_op [N], m_dst [N], m_t1 [N], m_t2 [N];
  logic [15:0] m_v1 [N], m_v2 [N];

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic bit hit(bit rdy, logic [3:0] t);
    return bv && !rdy && t == bt;
  endfunction

  task automatic idle();
    flush = 0; sv = 0; rs = 0; av = 0; bv = 0;
    aop = 0; adst = 0; s1t = 0; s2t = 0; s1r = 0; s2r = 0;
    s1v = 0; s2v = 0; bt = 0; bd = 0;
  endtask

  task automatic alloc(input logic [3:0] op, input logic [3:0] t1, input bit r1,
                       input logic [15:0] v1, input logic [3:0] t2, input bit r2,
                       input logic [15:0] v2);
    av = 1; aop = op; adst = op ^ 4'h9; s1t = t1; s1r = r1; s1v = v1;
    s2t = t2; s2r = r2; s2v = v2;
  endtask

  task automatic step(input string r);
    int g, a;
    bit fire;
    #1;
    g = -1; a = -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_busy[i] && m_r1[i] && m_r2[i]) g = i;
      if (!m_busy[i]) a = i;
    end
    chk(ardy === (a >= 0), r, {63'd0, ardy}, {63'd0, a >= 0});
    if (g < 0) chk(iv === 1'b0, r, {63'd0, iv}, 64'd0);
    else chk(iv === 1'b1 && {iidx, iop, idst, iv1, iv2} ===
             {3'(g), m_op[g], m_dst[g], m_v1[g], m_v2[g]}, r,
             {20'd0, iv, iidx, iop, idst, iv1, iv2},
             {20'd0, 1'b1, 3'(g), m_op[g], m_dst[g], m_v1[g], m_v2[g]});
    fire = av && a >= 0 && !flush && !rs;
    for (int i = 0; i < N; i++) begin
      if (hit(m_r1[i], m_t1[i])) begin m_r1[i] = 1; m_v1[i] = bd; end
      if (hit(m_r2[i], m_t2[i])) begin m_r2[i] = 1; m_v2[i] = bd; end
    end
    if (fire) begin
      m_op[a] = aop; m_dst[a] = adst; m_t1[a] = s1t; m_t2[a] = s2t;
      m_r1[a] = s1r || hit(s1r, s1t); m_v1[a] = hit(s1r, s1t) ? bd : s1v;
      m_r2[a] = s2r || hit(s2r, s2t); m_v2[a] = hit(s2r, s2t) ? bd : s2v;
    end
    for (int i = 0; i < N; i++) begin
      bit nb, cb;
      nb = m_busy[i] && i != g;
      cb = sv ? m_busy[i] : m_ck[i];
      if (flush) nb = 0;
      else if (rs) nb = nb && m_ck[i];
      else if (fire && i == a) nb = 1;
      m_busy[i] = nb; m_ck[i] = cb;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    for (int i = 0; i < N; i++) begin
      m_busy[i] = 0; m_ck[i] = 0; m_r1[i] = 0; m_r2[i] = 0;
      m_op[i] = 0; m_dst[i] = 0; m_t1[i] = 0; m_t2[i] = 0; m_v1[i] = 0; m_v2[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    step("R1");
    // R2: ready operands issue next cycle from slot 0
    alloc(4'h3, 4'h0, 1, 16'h1111, 4'h0, 1, 16'h2222); step("R2");
    idle(); step("R2"); step("R6");
    // R3: waiting source, wrong tag then right tag
    alloc(4'h5, 4'h5, 0, 16'hdead, 4'h1, 1, 16'h0042); step("R3");
    idle(); bv = 1; bt = 4'h6; bd = 16'hbad0; step("R3");
    bt = 4'h5; bd = 16'h7777; step("R3");
    idle(); step("R3"); step("R3");
    // R4: broadcast in the allocation cycle
    alloc(4'h7, 4'h7, 0, 16'h0, 4'h7, 0, 16'h0);
    bv = 1; bt = 4'h7; bd = 16'habcd; step("R4");
    idle(); step("R4"); step("R4");
    // R7: fill with distinct waiting tags, then a dropped request
    for (int i = 0; i < N; i++) begin
      alloc(4'(i), 4'(i), 0, 16'h0, 4'hf, 1, 16'(i * 3)); step("R7");
    end
    alloc(4'hc, 4'h0, 1, 16'h5555, 4'h0, 1, 16'h6666); step("R7");
    idle(); step("R7");
    // R6: out-of-order release of slot 3, reused by the next allocation
    bv = 1; bt = 4'h3; bd = 16'h3333; step("R6");
    idle(); step("R6");
    alloc(4'he, 4'h2, 1, 16'h0e0e, 4'h2, 1, 16'h1e1e); step("R6");
    idle(); step("R6"); step("R6");
    // R8: flush with an allocation in the same cycle
    flush = 1; alloc(4'h1, 4'h0, 1, 16'h1, 4'h0, 1, 16'h2); step("R8");
    idle(); step("R8");
    // R9: save, allocate more, restore with dropped allocation
    alloc(4'h2, 4'ha, 0, 16'h0, 4'hb, 1, 16'h1); step("R9");
    alloc(4'h4, 4'ha, 0, 16'h0, 4'hb, 1, 16'h2); step("R9");
    idle(); sv = 1; step("R9");
    alloc(4'h6, 4'ha, 0, 16'h0, 4'hb, 1, 16'h3); step("R9");
    alloc(4'h8, 4'ha, 0, 16'h0, 4'hb, 1, 16'h4); step("R9");
    idle(); rs = 1; alloc(4'h9, 4'h0, 1, 16'h9, 4'h0, 1, 16'h9); step("R9");
    idle(); bv = 1; bt = 4'ha; bd = 16'haaaa; step("R9");
    idle(); repeat (4) step("R9");
    // random mix
    for (int c = 0; c < 4000; c++) begin
      idle();
      if ($urandom_range(9) < 6)
        alloc(4'($urandom), 4'($urandom), 1'($urandom_range(1)), 16'($urandom),
              4'($urandom), 1'($urandom_range(1)), 16'($urandom));
      bv = 1'($urandom_range(1)); bt = 4'($urandom); bd = 16'($urandom);
      flush = ($urandom_range(63) == 0);
      sv = ($urandom_range(15) == 0);
      rs = ($urandom_range(31) == 0);
      step("R5");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule